// File: doc/BRIEF.md
# Big-Endian Sub-Word RAM Port

This block is a small word-organised memory of 32-bit words that sits behind a byte-addressed bus window. A bus master issues byte, halfword or word reads and writes at any address. The block subtracts the window's base address and uses the offset above the two low bits to select a word. Within each word the byte lanes run in big-endian order: the lowest byte address holds the most significant byte. Narrow writes merge into the stored word and leave the other lanes untouched. Narrow reads come back right-justified and zero-extended, one cycle after the request.

A second, word-wide maintenance port addresses the same storage by byte offset. It only accepts word-aligned offsets that fall inside the memory. A request that breaks either rule is refused, and the block reports which rule was broken. Every word is cleared to zero by the synchronous reset.

Top module: `subword_ram`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every word reads as zero and `bus_rvalid`, `dbg_done`, `dbg_err_align` and `dbg_err_range` are low.
- R2: The word index is (`bus_addr` − `BASE_ADDR`) shifted right by two. A word access (size 2'b10) reads or writes all 32 bits of that word and ignores address bits 1:0.
- R3: A byte access (size 2'b00) uses lane offset `bus_addr[1:0]`. Offset 0 is bits 31:24, offset 1 is bits 23:16, offset 2 is bits 15:8 and offset 3 is bits 7:0. A byte write changes only that lane.
- R4: A halfword access (size 2'b01) uses bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1, and ignores address bit 0. A halfword write leaves the other half unchanged.
- R5: For every bus read request, `bus_rvalid` is high in the next cycle. Byte data then sits in bits 7:0 and halfword data in bits 15:0, with the upper bits zero. The value returned is the word's content before any write made in the same cycle as the request.
- R6: Size code 2'b11 and any address whose offset from `BASE_ADDR` is at least 4·`DEPTH_WORDS` have no effect on a write and return zero on a read.
- R7: A maintenance request whose `dbg_addr[1:0]` is non-zero is refused with `dbg_err_align` and does not touch memory. This error takes precedence over the range error.
- R8: An aligned maintenance request with `dbg_addr` ≥ 4·`DEPTH_WORDS` is refused with `dbg_err_range` and does not touch memory. Its address must not alias onto a lower word.
- R9: A maintenance request raises `dbg_done` in the next cycle. An accepted read returns the whole word on `dbg_rdata`; otherwise `dbg_rdata` is zero. An accepted write replaces the whole word.
- R10: When a maintenance write and a bus write hit the same word in one cycle, the maintenance word is applied first and the bus lanes are merged on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_addr | input | ADDR_W | Byte address on the bus |
| bus_wdata | input | 32 | Write data, right-justified for narrow sizes |
| bus_rdata | output | 32 | Read data, zero-extended |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| dbg_req | input | 1 | Maintenance request |
| dbg_we | input | 1 | Maintenance write (1) or read (0) |
| dbg_addr | input | DBG_AW | Byte offset into the memory |
| dbg_wdata | input | 32 | Maintenance write word |
| dbg_rdata | output | 32 | Maintenance read word |
| dbg_done | output | 1 | Maintenance request answered |
| dbg_err_align | output | 1 | Request refused: offset not word-aligned |
| dbg_err_range | output | 1 | Request refused: offset beyond memory |

## Verification
Two operations can land in the same cycle: a full-word write from the maintenance port and a narrow bus write to the same word. The bench drives both at once, with a byte lane that the maintenance word also covers. It expects the maintenance value everywhere except that lane, which must carry the bus byte. It also drives a maintenance write together with a bus read of the same word, and expects the read to return the word's content from before the write. Random traffic then mixes both ports over nearby words. A behavioural model judges every cycle, and it applies the maintenance write before the bus merge.

// File: rtl/ber_pkg.sv
package ber_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;

    // Size codes as they appear on the bus.
    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

    // Outcome of a maintenance-port address check.
    typedef enum logic [1:0] {
        DBG_OK    = 2'b00,
        DBG_ALIGN = 2'b01,
        DBG_RANGE = 2'b10
    } dbg_status_e;

    // Lane selection: how far the lane sits from bit 0, which bits it
    // covers, and whether the size code is usable at all.
    typedef struct packed {
        logic [4:0]        shift;
        logic [WORD_W-1:0] mask;
        logic              legal;
    } lane_sel_t;

    // Big-endian placement: byte offset 0 is the top lane.
    function automatic lane_sel_t lane_decode(acc_size_e sz, logic [1:0] off);
        lane_sel_t s;
        s.shift = 5'd0;
        s.mask  = '0;
        s.legal = 1'b1;
        unique case (sz)
            ACC_BYTE: begin
                s.shift = {~off, 3'b000};
                s.mask  = 32'h0000_00FF << s.shift;
            end
            ACC_HALF: begin
                s.shift = off[1] ? 5'd0 : 5'd16;
                s.mask  = 32'h0000_FFFF << s.shift;
            end
            ACC_WORD: begin
                s.shift = 5'd0;
                s.mask  = 32'hFFFF_FFFF;
            end
            default: begin
                s.legal = 1'b0;
            end
        endcase
        return s;
    endfunction

    // Lift right-justified write data into its lane.
    function automatic logic [WORD_W-1:0] lane_place(logic [WORD_W-1:0] wdata,
                                                     lane_sel_t s);
        return (wdata << s.shift) & s.mask;
    endfunction

    // Bring the selected lane down to bit 0, upper bits zero.
    function automatic logic [WORD_W-1:0] lane_extract(logic [WORD_W-1:0] word,
                                                       lane_sel_t s);
        return (word & s.mask) >> s.shift;
    endfunction

endpackage

// File: rtl/ber_bus_decode.sv
module ber_bus_decode
    import ber_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0004_3000,
    parameter int          DEPTH_WORDS = 64,
    parameter int          IDX_W       = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  index,
    output logic              in_window,
    output lane_sel_t         lane
);
    localparam logic [ADDR_W:0] WIN_BYTES = (ADDR_W+1)'(DEPTH_WORDS * 4);
    localparam logic [ADDR_W-1:0] BASE_W  = ADDR_W'(BASE_ADDR);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset    = addr - BASE_W;
        in_window = ({1'b0, offset} < WIN_BYTES);
        index     = offset[IDX_W+1:2];
        lane      = lane_decode(acc_size_e'(size), offset[1:0]);
    end

endmodule

// File: rtl/ber_dbg_check.sv
module ber_dbg_check
    import ber_pkg::*;
#(
    parameter int DBG_AW      = 16,
    parameter int DEPTH_WORDS = 64,
    parameter int IDX_W       = 6
) (
    input  logic [DBG_AW-1:0] addr,
    output dbg_status_e       status,
    output logic [IDX_W-1:0]  index
);
    localparam logic [DBG_AW:0] MEM_BYTES = (DBG_AW+1)'(DEPTH_WORDS * 4);

    always_comb begin
        index = addr[IDX_W+1:2];
        if (addr[1:0] != 2'b00) begin
            status = DBG_ALIGN;
        end else if ({1'b0, addr} >= MEM_BYTES) begin
            status = DBG_RANGE;
        end else begin
            status = DBG_OK;
        end
    end

endmodule

// File: rtl/ber_store.sv
module ber_store
    import ber_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    parameter int IDX_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  bus_rd_idx,
    output logic [WORD_W-1:0] bus_rd_word,
    input  logic [IDX_W-1:0]  dbg_rd_idx,
    output logic [WORD_W-1:0] dbg_rd_word,
    input  logic              dbg_wr_en,
    input  logic [IDX_W-1:0]  dbg_wr_idx,
    input  logic [WORD_W-1:0] dbg_wr_data,
    input  logic              bus_wr_en,
    input  logic [IDX_W-1:0]  bus_wr_idx,
    input  logic [WORD_W-1:0] bus_wr_mask,
    input  logic [WORD_W-1:0] bus_wr_data
);
    logic [WORD_W-1:0] mem_q [DEPTH_WORDS];
    logic [WORD_W-1:0] mem_d [DEPTH_WORDS];

    // Per-word next value: maintenance word first, bus lanes on top.
    for (genvar g = 0; g < DEPTH_WORDS; g++) begin : g_word
        logic              dbg_hit;
        logic              bus_hit;
        logic [WORD_W-1:0] base_val;

        assign dbg_hit  = dbg_wr_en && (dbg_wr_idx == IDX_W'(g));
        assign bus_hit  = bus_wr_en && (bus_wr_idx == IDX_W'(g));
        assign base_val = dbg_hit ? dbg_wr_data : mem_q[g];
        assign mem_d[g] = bus_hit ? ((base_val & ~bus_wr_mask) | bus_wr_data)
                                  : base_val;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH_WORDS; i++) begin
            if (rst) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign bus_rd_word = mem_q[bus_rd_idx];
    assign dbg_rd_word = mem_q[dbg_rd_idx];

endmodule

// File: rtl/subword_ram.sv
module subword_ram
    import ber_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE_ADDR   = 32'h0004_3000,
    parameter int          DEPTH_WORDS = 64,
    parameter int          DBG_AW      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              dbg_req,
    input  logic              dbg_we,
    input  logic [DBG_AW-1:0] dbg_addr,
    input  logic [31:0]       dbg_wdata,
    output logic [31:0]       dbg_rdata,
    output logic              dbg_done,
    output logic              dbg_err_align,
    output logic              dbg_err_range
);
    localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;

    logic [IDX_W-1:0]  bus_idx;
    logic              bus_in_win;
    lane_sel_t         bus_lane;
    logic [IDX_W-1:0]  dbg_idx;
    dbg_status_e       dbg_stat;
    logic [WORD_W-1:0] bus_word;
    logic [WORD_W-1:0] dbg_word;
    logic              bus_ok;
    logic              bus_wr_go;
    logic              dbg_wr_go;

    ber_bus_decode #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .DEPTH_WORDS (DEPTH_WORDS),
        .IDX_W       (IDX_W)
    ) u_bus_decode (
        .addr      (bus_addr),
        .size      (bus_size),
        .index     (bus_idx),
        .in_window (bus_in_win),
        .lane      (bus_lane)
    );

    ber_dbg_check #(
        .DBG_AW      (DBG_AW),
        .DEPTH_WORDS (DEPTH_WORDS),
        .IDX_W       (IDX_W)
    ) u_dbg_check (
        .addr   (dbg_addr),
        .status (dbg_stat),
        .index  (dbg_idx)
    );

    assign bus_ok    = bus_in_win && bus_lane.legal;
    assign bus_wr_go = bus_req && bus_we && bus_ok;
    assign dbg_wr_go = dbg_req && dbg_we && (dbg_stat == DBG_OK);

    ber_store #(
        .DEPTH_WORDS (DEPTH_WORDS),
        .IDX_W       (IDX_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .bus_rd_idx  (bus_idx),
        .bus_rd_word (bus_word),
        .dbg_rd_idx  (dbg_idx),
        .dbg_rd_word (dbg_word),
        .dbg_wr_en   (dbg_wr_go),
        .dbg_wr_idx  (dbg_idx),
        .dbg_wr_data (dbg_wdata),
        .bus_wr_en   (bus_wr_go),
        .bus_wr_idx  (bus_idx),
        .bus_wr_mask (bus_lane.mask),
        .bus_wr_data (lane_place(bus_wdata, bus_lane))
    );

    // Bus read response: one cycle after the request, pre-write contents.
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            if (bus_req && !bus_we) begin
                bus_rdata <= bus_ok ? lane_extract(bus_word, bus_lane) : '0;
            end
        end
    end

    // Maintenance response.
    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_done      <= 1'b0;
            dbg_err_align <= 1'b0;
            dbg_err_range <= 1'b0;
            dbg_rdata     <= '0;
        end else begin
            dbg_done      <= dbg_req;
            dbg_err_align <= dbg_req && (dbg_stat == DBG_ALIGN);
            dbg_err_range <= dbg_req && (dbg_stat == DBG_RANGE);
            dbg_rdata     <= (dbg_req && !dbg_we && dbg_stat == DBG_OK) ? dbg_word : '0;
        end
    end

endmodule

// File: rtl/subword_ram_chk.sv
module subword_ram_chk #(
    parameter int ADDR_W      = 32,
    parameter int DEPTH_WORDS = 64,
    parameter int DBG_AW      = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              dbg_req,
    input logic [DBG_AW-1:0] dbg_addr,
    input logic [31:0]       dbg_rdata,
    input logic              dbg_done,
    input logic              dbg_err_align,
    input logic              dbg_err_range
);
    localparam logic [DBG_AW:0] MEM_BYTES = (DBG_AW+1)'(DEPTH_WORDS * 4);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bus_rvalid && !dbg_done && !dbg_err_align && !dbg_err_range));

    // R5
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R5
    byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_size == 2'b00) |=> (bus_rdata[31:8] == 24'd0));

    // R5
    half_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_size == 2'b01) |=> (bus_rdata[31:16] == 16'd0));

    // R6
    rsvd_size_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_size == 2'b11) |=> (bus_rdata == 32'd0));

    // R7
    align_err_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && dbg_addr[1:0] != 2'b00) |=> (dbg_err_align && !dbg_err_range));

    // R8
    range_err_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && dbg_addr[1:0] == 2'b00 && {1'b0, dbg_addr} >= MEM_BYTES)
            |=> (dbg_err_range && dbg_rdata == 32'd0));

    // R9
    dbg_answer_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_req |=> dbg_done);

    // R7
    one_error_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dbg_err_align, dbg_err_range}));

endmodule

bind subword_ram subword_ram_chk #(
    .ADDR_W      (ADDR_W),
    .DEPTH_WORDS (DEPTH_WORDS),
    .DBG_AW      (DBG_AW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_size      (bus_size),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .dbg_req       (dbg_req),
    .dbg_addr      (dbg_addr),
    .dbg_rdata     (dbg_rdata),
    .dbg_done      (dbg_done),
    .dbg_err_align (dbg_err_align),
    .dbg_err_range (dbg_err_range)
);

// File: tb/subword_ram_bench.sv
`timescale 1ns/1ps
module subword_ram_bench;
    localparam logic [31:0] BASE  = 32'h0004_3000;
    localparam int          DEPTH = 64;
    localparam int          BYTES = DEPTH * 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 0, bus_we = 0;
    logic [1:0]  bus_size = 0;
    logic [31:0] bus_addr = 0, bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        dbg_req = 0, dbg_we = 0;
    logic [15:0] dbg_addr = 0;
    logic [31:0] dbg_wdata = 0;
    logic [31:0] dbg_rdata;
    logic        dbg_done, dbg_err_align, dbg_err_range;

    always #4 clk = ~clk;   // 125 MHz

    subword_ram u_subword_ram (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_done(dbg_done),
        .dbg_err_align(dbg_err_align), .dbg_err_range(dbg_err_range)
    );

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    // Behavioural reference model.
    logic [31:0] model [DEPTH];
    logic [31:0] e_rdata = 0, e_drdata = 0;
    logic        e_rvalid = 0, e_done = 0, e_align = 0, e_range = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        exp_tag = cur_tag;
        if (rst) begin
            foreach (model[i]) model[i] = 0;
            e_rdata = 0; e_rvalid = 0; e_done = 0; e_align = 0; e_range = 0; e_drdata = 0;
        end else begin
            longint off;
            int     didx;
            off = longint'(bus_addr) - longint'(BASE);
            // reads see the old contents
            e_rvalid = bus_req && !bus_we;
            if (bus_req && !bus_we) begin
                e_rdata = 0;
                if (off >= 0 && off < BYTES) begin
                    logic [31:0] w;
                    w = model[off / 4];
                    case (bus_size)
                        2'b00: e_rdata = (w >> (8 * (3 - (off % 4)))) & 32'hFF;
                        2'b01: e_rdata = ((off % 4) >= 2) ? (w & 32'hFFFF) : (w >> 16);
                        2'b10: e_rdata = w;
                        default: e_rdata = 0;
                    endcase
                end
            end
            e_done   = dbg_req;
            e_align  = dbg_req && (dbg_addr % 4 != 0);
            e_range  = dbg_req && (dbg_addr % 4 == 0) && (dbg_addr >= BYTES);
            didx     = dbg_addr / 4;
            e_drdata = (dbg_req && !dbg_we && !e_align && !e_range) ? model[didx] : 0;
            // maintenance write first, then bus merge
            if (dbg_req && dbg_we && (dbg_addr % 4 == 0) && dbg_addr < BYTES)
                model[didx] = dbg_wdata;
            if (bus_req && bus_we && off >= 0 && off < BYTES) begin
                int p;
                case (bus_size)
                    2'b00: begin
                        p = 3 - int'(off % 4);
                        model[off / 4][8*p +: 8] = bus_wdata[7:0];
                    end
                    2'b01: begin
                        if ((off % 4) >= 2) model[off / 4][15:0]  = bus_wdata[15:0];
                        else                model[off / 4][31:16] = bus_wdata[15:0];
                    end
                    2'b10: model[off / 4] = bus_wdata;
                    default: ;
                endcase
            end
        end
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        check({exp_tag, " rvalid"}, {31'd0, bus_rvalid}, {31'd0, e_rvalid});
        check({exp_tag, " rdata"}, bus_rdata, e_rdata);
        check({exp_tag, " dbg"}, {29'd0, dbg_done, dbg_err_align, dbg_err_range},
              {29'd0, e_done, e_align, e_range});
        check({exp_tag, " drdata"}, dbg_rdata, e_drdata);
    end

    // One cycle with both ports; returns at the negedge where results show.
    task automatic step(input logic br, input logic bw, input logic [1:0] bs,
                        input logic [31:0] ba, input logic [31:0] bd,
                        input logic dr, input logic dw, input logic [15:0] da,
                        input logic [31:0] dd);
        bus_req = br; bus_we = bw; bus_size = bs; bus_addr = ba; bus_wdata = bd;
        dbg_req = dr; dbg_we = dw; dbg_addr = da; dbg_wdata = dd;
        @(negedge clk);
        bus_req = 0; bus_we = 0; dbg_req = 0; dbg_we = 0;
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [31:0] a, input logic [31:0] d);
        step(1, 1, s, a, d, 0, 0, 0, 0);
    endtask
    task automatic bus_rd(input logic [1:0] s, input logic [31:0] a);
        step(1, 0, s, a, 0, 0, 0, 0, 0);
    endtask
    task automatic dbg_wr(input logic [15:0] a, input logic [31:0] d);
        step(0, 0, 0, 0, 0, 1, 1, a, d);
    endtask
    task automatic dbg_rd(input logic [15:0] a);
        step(0, 0, 0, 0, 0, 1, 0, a, 0);
    endtask

    initial begin
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 rvalid after reset", {31'd0, bus_rvalid}, 0);
        bus_rd(2'b10, BASE + 32'd20);
        check("R1 word zero", bus_rdata, 32'h0);

        cur_tag = "R2";
        bus_wr(2'b10, BASE + 32'd11, 32'h1122_3344);
        bus_rd(2'b10, BASE + 32'd8);
        check("R2 word", bus_rdata, 32'h1122_3344);
        dbg_rd(16'd8);
        check("R2 index", dbg_rdata, 32'h1122_3344);

        cur_tag = "R3";
        bus_rd(2'b00, BASE + 32'd8);  check("R3 off0", bus_rdata, 32'h11);
        bus_rd(2'b00, BASE + 32'd9);  check("R3 off1", bus_rdata, 32'h22);
        bus_rd(2'b00, BASE + 32'd10); check("R3 off2", bus_rdata, 32'h33);
        bus_rd(2'b00, BASE + 32'd11); check("R3 off3", bus_rdata, 32'h44);
        bus_wr(2'b00, BASE + 32'd9, 32'hFFFF_FFAB);
        dbg_rd(16'd8);
        check("R3 byte merge", dbg_rdata, 32'h11AB_3344);

        cur_tag = "R4";
        bus_rd(2'b01, BASE + 32'd9);  check("R4 upper half", bus_rdata, 32'h11AB);
        bus_rd(2'b01, BASE + 32'd10); check("R4 lower half", bus_rdata, 32'h3344);
        bus_wr(2'b01, BASE + 32'd11, 32'h7777_CDEF);
        dbg_rd(16'd8);
        check("R4 half merge", dbg_rdata, 32'h11AB_CDEF);

        cur_tag = "R5";
        step(1, 0, 2'b00, BASE + 32'd8, 0, 1, 1, 16'd8, 32'h5566_7788);
        check("R5 read before write", bus_rdata, 32'h11);
        check("R5 valid", {31'd0, bus_rvalid}, 1);
        bus_rd(2'b01, BASE + 32'd8);
        check("R5 half zext", bus_rdata, 32'h5566);

        cur_tag = "R6";
        bus_wr(2'b11, BASE + 32'd12, 32'hFFFF_FFFF);
        dbg_rd(16'd12);
        check("R6 reserved size write", dbg_rdata, 32'h0);
        bus_wr(2'b10, BASE + BYTES, 32'hDEAD_0001);
        dbg_rd(16'd0);
        check("R6 beyond window", dbg_rdata, 32'h0);
        bus_wr(2'b10, BASE - 32'd4, 32'hDEAD_0002);
        dbg_rd(16'd252);
        check("R6 below window", dbg_rdata, 32'h0);
        bus_rd(2'b11, BASE + 32'd8);
        check("R6 reserved read", bus_rdata, 32'h0);

        cur_tag = "R7";
        dbg_rd(16'd6);
        check("R7 align flag", {30'd0, dbg_err_align, dbg_err_range}, 32'h2);
        dbg_wr(16'd5, 32'hBAD0_BAD0);
        dbg_rd(16'd4);
        check("R7 no write", dbg_rdata, 32'h0);
        dbg_rd(16'h0101);
        check("R7 precedence", {30'd0, dbg_err_align, dbg_err_range}, 32'h2);

        cur_tag = "R8";
        dbg_rd(16'd256);
        check("R8 range flag", {30'd0, dbg_err_align, dbg_err_range}, 32'h1);
        dbg_wr(16'h0200, 32'hBAD1_BAD1);
        dbg_rd(16'd0);
        check("R8 no alias", dbg_rdata, 32'h0);

        cur_tag = "R9";
        dbg_wr(16'd252, 32'hDEAD_BEEF);
        check("R9 done", {31'd0, dbg_done}, 1);
        check("R9 write rdata zero", dbg_rdata, 32'h0);
        dbg_rd(16'd252);
        check("R9 read", dbg_rdata, 32'hDEAD_BEEF);
        bus_rd(2'b10, BASE + 32'd252);
        check("R9 via bus", bus_rdata, 32'hDEAD_BEEF);

        cur_tag = "R10";
        step(1, 1, 2'b00, BASE + 32'd22, 32'h0000_005C, 1, 1, 16'd20, 32'hA0A0_A0A0);
        dbg_rd(16'd20);
        check("R10 merge order", dbg_rdata, 32'hA0A0_5CA0);

        // Mixed traffic on both ports, judged by the model each cycle.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            cur_tag = (r[1:0] == 2'b00) ? "R3" : (r[1:0] == 2'b01) ? "R4" :
                      (r[1:0] == 2'b10) ? "R2" : "R6";
            step(r[2], r[3], r[1:0], BASE + 32'd32 - 32'd8 + {26'd0, r[9:4]}, $urandom,
                 r[10], r[11], {10'd0, r[17:12]} + 16'd220, $urandom);
            if (r[10]) cur_tag = "R10";
        end

        cur_tag = "R1";
        rst = 1;
        @(negedge clk);
        rst = 0;
        dbg_rd(16'd8);
        check("R1 cleared", dbg_rdata, 32'h0);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule